// File: doc/BRIEF.md
# Multi-Channel Logic Trigger Matcher

This block watches a 16-channel bus of sampled logic inputs and produces a one-cycle trigger pulse when every enabled channel meets its condition. It also produces a latched trigger flag. A channel can match a steady high, a steady low, a rising edge or a falling edge. No more than one channel may use an edge condition at a time. If more than one does, the block reports a configuration error and does not fire.

Conditions are held in four per-channel masks, loaded through a word-wide register write port:

- **capture**: which channels exist for this run.
- **enable**: which channels take part in the trigger.
- **level**: level condition (1) or edge condition (0).
- **polarity**: which level or which edge.

The block evaluates only on cycles where the sample-enable input is high. Those cycles are the divided sample ticks of the acquisition path. The block only fires while the arm input is held high. After it fires, it stays latched until arm is dropped and raised again.

Top module: `trig_matcher`

## Requirements
- R1: After a synchronous reset, `trig_pulse`, `trig_hold` and `cfg_err` are 0 and all four masks are 0.
- R2: A write with `cfg_we`=1 loads bits [15:0] of `cfg_wdata` into the mask chosen by `cfg_addr`: 0 = capture, 1 = enable, 2 = level, 3 = polarity. Bits [31:16] are ignored.
- R3: A channel with level bit 1 matches when its input equals its polarity bit (1 = high, 0 = low).
- R4: A channel with level bit 0 detects an edge against the previously sampled value. Polarity 0 means rising (0 then 1) and polarity 1 means falling (1 then 0). No edge can match before the first sample after reset.
- R5: All active channels (capture bit 1 and enable bit 1) must match in the same sample for the trigger to fire.
- R6: Evaluation and the update of the previous-sample register happen only on cycles with `sample_en`=1. Input changes between samples are not seen.
- R7: `cfg_err` goes high one cycle after the masks come to hold more than one active channel with level bit 0. While that is the case, the block never fires.
- R8: With no active channel, the block fires on the first sample taken while `arm` is 1.
- R9: Behaviour of the pulse and latch:
  - `trig_pulse` is high for exactly the one cycle after the firing sample.
  - `trig_hold` rises with the pulse and stays high while `arm` is 1.
  - `trig_hold` clears the cycle after `arm` is 0.
  - The block does not fire again until it is re-armed, and never fires while `arm` is 0.
- R10: A channel whose capture bit is 0 is excluded from the trigger, even if its enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mask write strobe |
| cfg_addr | input | 2 | Mask select for the write |
| cfg_wdata | input | 32 | Write data; low 16 bits used |
| sample_en | input | 1 | Sample tick qualifier |
| arm | input | 1 | Trigger arm level |
| din | input | 16 | Sampled logic inputs |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| trig_hold | output | 1 | Latched trigger flag |
| cfg_err | output | 1 | More than one edge channel active |

## Verification
A wrong previous-sample register makes an edge appear one sample early or late, or makes a spurious edge appear on a tick. Because `trig_pulse` is registered, that error shows on the pulse output on the cycle right after the offending tick. A stale error flag or a stale arm latch shows in the same way. It either suppresses a pulse the reference model expects, or it lets a second pulse through. The reference model is compared against all three outputs on every clock, so any such divergence is caught within one cycle of its cause.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int unsigned CH_N   = 16;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    W_CAPTURE = 2'd0,
    W_ENABLE  = 2'd1,
    W_LEVEL   = 2'd2,
    W_POLAR   = 2'd3
  } cfg_word_e;
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_pkg::*;
#(
  parameter int unsigned CH = CH_N,
  parameter int unsigned DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [CH-1:0] cap_q,
  output logic [CH-1:0] en_q,
  output logic [CH-1:0] lvl_q,
  output logic [CH-1:0] pol_q,
  output logic          err_now,
  output logic          err_q
);
  localparam int unsigned CW = $clog2(CH + 1);

  logic unused_hi;
  assign unused_hi = ^wdata[DW-1:CH];

  logic [CH-1:0] edge_ch;
  logic [CW-1:0] edge_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= '0;
      en_q  <= '0;
      lvl_q <= '0;
      pol_q <= '0;
    end else if (we) begin
      case (cfg_word_e'(addr))
        W_CAPTURE: cap_q <= wdata[CH-1:0];
        W_ENABLE:  en_q  <= wdata[CH-1:0];
        W_LEVEL:   lvl_q <= wdata[CH-1:0];
        default:   pol_q <= wdata[CH-1:0];
      endcase
    end
  end

  assign edge_ch = cap_q & en_q & ~lvl_q;

  always_comb begin
    edge_cnt = '0;
    for (int i = 0; i < CH; i++) edge_cnt = edge_cnt + CW'(edge_ch[i]);
  end

  assign err_now = (edge_cnt > CW'(1));

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= err_now;
  end

  // R2: enable write lands in the next cycle
  a_r2_enable_write: assert property (@(posedge clk) disable iff (rst)
    (we && addr == 2'd1) |=> (en_q == $past(wdata[CH-1:0])));
  // R2: no write, masks unchanged
  a_r2_masks_hold: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(cap_q) && $stable(lvl_q) && $stable(pol_q) && $stable(en_q)));
  // R7: registered error follows the mask state
  a_r7_err_tracks: assert property (@(posedge clk) disable iff (rst)
    err_q == $past(err_now));
endmodule

// File: rtl/trig_chan_eval.sv
module trig_chan_eval
  import trig_pkg::*;
#(
  parameter int unsigned CH = CH_N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_en,
  input  logic [CH-1:0] din,
  input  logic [CH-1:0] cap,
  input  logic [CH-1:0] en,
  input  logic [CH-1:0] lvl,
  input  logic [CH-1:0] pol,
  output logic          match
);
  logic [CH-1:0] prev_q;
  logic          prev_vld_q;
  logic [CH-1:0] ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else if (sample_en) begin
      prev_q     <= din;
      prev_vld_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic lvl_hit, rise, fall, edge_hit, cond;
    always_comb begin
      lvl_hit  = ~(din[i] ^ pol[i]);
      rise     = ~prev_q[i] & din[i];
      fall     = prev_q[i] & ~din[i];
      edge_hit = prev_vld_q & (pol[i] ? fall : rise);
      cond     = lvl[i] ? lvl_hit : edge_hit;
      ok[i]    = ~(en[i] & cap[i]) | cond;
    end
  end

  assign match = &ok;

  // R6: previous sample captured on a tick
  a_r6_prev_tracks: assert property (@(posedge clk) disable iff (rst)
    sample_en |=> (prev_q == $past(din)));
  // R6: previous sample frozen between ticks
  a_r6_prev_holds: assert property (@(posedge clk) disable iff (rst)
    !sample_en |=> $stable(prev_q));
endmodule

// File: rtl/trig_fire_ctl.sv
module trig_fire_ctl (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic sample_en,
  input  logic match,
  input  logic err_now,
  output logic pulse,
  output logic hold
);
  logic fire;

  assign fire = arm & ~hold & sample_en & match & ~err_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
      hold  <= 1'b0;
    end else begin
      pulse <= fire;
      hold  <= arm & (hold | fire);
    end
  end

  // R9: pulse lasts one cycle
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
  // R9: pulse comes with the latch
  a_r9_pulse_sets_hold: assert property (@(posedge clk) disable iff (rst)
    pulse |-> hold);
  // R9: disarm clears the latch
  a_r9_disarm_clears: assert property (@(posedge clk) disable iff (rst)
    !arm |=> !hold);
  // R7: never fire with an error in the masks
  a_r7_no_fire_on_err: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(!err_now));
  // R6: firing only follows a sample tick
  a_r6_needs_sample: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(sample_en && arm));
endmodule

// File: rtl/trig_matcher.sv
module trig_matcher
  import trig_pkg::*;
#(
  parameter int unsigned CH = CH_N,
  parameter int unsigned DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          sample_en,
  input  logic          arm,
  input  logic [CH-1:0] din,
  output logic          trig_pulse,
  output logic          trig_hold,
  output logic          cfg_err
);
  logic [CH-1:0] cap, en, lvl, pol;
  logic          err_now, match;

  trig_cfg_regs #(.CH(CH), .DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .cap_q(cap), .en_q(en), .lvl_q(lvl), .pol_q(pol),
    .err_now(err_now), .err_q(cfg_err)
  );

  trig_chan_eval #(.CH(CH)) u_eval (
    .clk(clk), .rst(rst), .sample_en(sample_en), .din(din),
    .cap(cap), .en(en), .lvl(lvl), .pol(pol), .match(match)
  );

  trig_fire_ctl u_fire (
    .clk(clk), .rst(rst), .arm(arm), .sample_en(sample_en),
    .match(match), .err_now(err_now), .pulse(trig_pulse), .hold(trig_hold)
  );

  // R1: outputs quiet right after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!trig_pulse && !trig_hold && !cfg_err));
endmodule

// File: tb/trig_matcher_tb.sv
`timescale 1ns/1ps
module trig_matcher_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        sample_en = 1'b0;
  logic        arm = 1'b0;
  logic [15:0] din = 16'd0;
  logic        trig_pulse, trig_hold, cfg_err;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  trig_matcher u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sample_en(sample_en), .arm(arm), .din(din),
    .trig_pulse(trig_pulse), .trig_hold(trig_hold), .cfg_err(cfg_err)
  );

  // behavioural reference
  bit [15:0] m_cap, m_en, m_lvl, m_pol, m_prev;
  bit        m_seen, m_pulse, m_hold, m_err;

  always @(posedge clk) begin
    if (rst) begin
      m_cap = 0; m_en = 0; m_lvl = 0; m_pol = 0; m_prev = 0;
      m_seen = 0; m_pulse = 0; m_hold = 0; m_err = 0;
    end else begin
      int  edges;
      bit  good;
      bit  fire;
      edges = 0;
      good  = 1;
      for (int i = 0; i < 16; i++) begin
        if (m_cap[i] && m_en[i]) begin
          if (m_lvl[i]) begin
            if (din[i] != m_pol[i]) good = 0;
          end else begin
            edges++;
            if (!m_seen) good = 0;
            else if (m_pol[i] == 0 && !(m_prev[i] == 0 && din[i] == 1)) good = 0;
            else if (m_pol[i] == 1 && !(m_prev[i] == 1 && din[i] == 0)) good = 0;
          end
        end
      end
      fire = arm && !m_hold && sample_en && good && (edges <= 1);
      m_pulse = fire;
      if (!arm) m_hold = 0;
      else if (fire) m_hold = 1;
      m_err = (edges > 1);
      if (sample_en) begin m_prev = din; m_seen = 1; end
      if (cfg_we) begin
        if (cfg_addr == 0) m_cap = cfg_wdata[15:0];
        else if (cfg_addr == 1) m_en = cfg_wdata[15:0];
        else if (cfg_addr == 2) m_lvl = cfg_wdata[15:0];
        else m_pol = cfg_wdata[15:0];
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(trig_pulse === m_pulse, cur_req, "pulse vs model", trig_pulse, m_pulse);
      check(trig_hold  === m_hold,  cur_req, "hold vs model",  trig_hold,  m_hold);
      check(cfg_err    === m_err,   cur_req, "err vs model",   cfg_err,    m_err);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic samp(input logic [15:0] d);
    din = d; sample_en = 1;
    @(negedge clk);
    sample_en = 0;
  endtask

  task automatic rearm();
    arm = 0;
    @(negedge clk);
    arm = 1;
  endtask

  task automatic expect_out(input bit p, input bit h, input string req);
    check(trig_pulse === p, req, "trig_pulse", trig_pulse, p);
    check(trig_hold === h,  req, "trig_hold",  trig_hold,  h);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 0;
    cur_req = "R1";
    step(1);
    expect_out(0, 0, "R1");
    check(cfg_err === 0, "R1", "cfg_err", cfg_err, 0);

    // R8: empty set fires on first armed sample
    cur_req = "R8";
    arm = 1;
    samp(16'h1234);
    expect_out(1, 1, "R8");
    // R9: latch holds, no second pulse
    cur_req = "R9";
    step(1);
    expect_out(0, 1, "R9");
    samp(16'h0000);
    expect_out(0, 1, "R9");
    arm = 0;
    step(1);
    expect_out(0, 0, "R9");
    samp(16'h0000);
    expect_out(0, 0, "R9");

    // R3: level high on ch0, low on ch1
    cur_req = "R3";
    wr(2'd0, 32'h0000_FFFF);
    wr(2'd1, 32'h0000_0003);
    wr(2'd2, 32'h0000_0003);
    wr(2'd3, 32'h0000_0001);
    rearm();
    samp(16'h0002);
    expect_out(0, 0, "R3");
    samp(16'h0003);
    expect_out(0, 0, "R3");
    samp(16'h0001);
    expect_out(1, 1, "R3");

    // R4 / R5: ch0 high AND ch4 rising
    cur_req = "R4";
    wr(2'd1, 32'h0000_0011);
    wr(2'd2, 32'h0000_0001);
    wr(2'd3, 32'h0000_0001);
    rearm();
    samp(16'h0001);
    expect_out(0, 0, "R4");
    samp(16'h0011);
    expect_out(1, 1, "R4");
    cur_req = "R5";
    rearm();
    samp(16'h0000);
    samp(16'h0010);
    expect_out(0, 0, "R5");
    samp(16'h0011);
    expect_out(0, 0, "R5");
    // falling on ch4
    cur_req = "R4";
    wr(2'd3, 32'h0000_0011);
    rearm();
    samp(16'h0001);
    expect_out(1, 1, "R4");

    // R6: unsampled changes are invisible
    cur_req = "R6";
    wr(2'd1, 32'h0000_0010);
    wr(2'd2, 32'h0000_0000);
    wr(2'd3, 32'h0000_0000);
    rearm();
    samp(16'h0000);
    din = 16'h0010; step(3);
    expect_out(0, 0, "R6");
    din = 16'h0000; step(1);
    samp(16'h0010);
    expect_out(1, 1, "R6");

    // R7: two edge channels
    cur_req = "R7";
    wr(2'd1, 32'h0000_0030);
    step(1);
    check(cfg_err === 1, "R7", "cfg_err", cfg_err, 1);
    rearm();
    samp(16'h0000);
    samp(16'h0030);
    expect_out(0, 0, "R7");
    wr(2'd2, 32'h0000_0020);
    wr(2'd3, 32'h0000_0020);
    step(1);
    check(cfg_err === 0, "R7", "cfg_err", cfg_err, 0);
    samp(16'h0000);
    samp(16'h0030);
    expect_out(1, 1, "R7");

    // R10: capture bit excludes channel
    cur_req = "R10";
    wr(2'd0, 32'h0000_FFFD);
    wr(2'd1, 32'h0000_0003);
    wr(2'd2, 32'h0000_0003);
    wr(2'd3, 32'h0000_0003);
    rearm();
    samp(16'h0001);
    expect_out(1, 1, "R10");

    // R2: upper half ignored -> empty enable mask
    cur_req = "R2";
    wr(2'd1, 32'hFFFF_0000);
    rearm();
    samp(16'h0000);
    expect_out(1, 1, "R2");

    step(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule